// File: doc/BRIEF.md
# Register Window onto Internal Word Memory

This block lets a host reach a large internal word memory through four 32-bit registers. The host uses a small synchronous register bus. One pair of registers, a pointer and a data port, gives random access: the host loads a byte address into the pointer, then reads or writes the data port. That data port accepts byte, halfword and full-word transfers. A second pair gives streaming writes. Each full-word write to its data port stores the word at the stream pointer, then moves the pointer forward by one word. The host can read the stream pointer back to find how far a fill has reached.

Behind the window sits a single-port memory with a fixed pipeline latency. All memory operations go through one in-order pipeline. A read therefore always sees every write accepted before it. Writes flow at one per cycle. A read stalls the bus until its data returns.

Top module: `mw_window`

## Requirements
- R1: After synchronous reset, the random-access pointer and the stream pointer both read back as 0.
- R2: The register offsets are 0x10 for the random-access pointer, 0x14 for the random-access data port, 0x18 for the stream pointer and 0x1C for the stream data port. A write to any other offset changes no state. A read of any other offset, or of the stream data port, returns 0.
- R3: A full-word read of the random-access data port returns the memory word selected by bits [IDX_W+1:2] of the random-access pointer, where IDX_W = log2(DEPTH). Pointer values therefore wrap modulo DEPTH words.
- R4: A write of the random-access data port takes its size from the byte enables: 4'b0001 is a byte, 4'b0011 is a halfword and 4'b1111 is a word. The host places the data in the low bits. The block moves it to the lane that the pointer's low bits select: bits [1:0] for a byte, bit 1 for a halfword. Only those bytes of the word change.
- R5: A narrow read of the random-access data port uses the same size and lane rules as R4. It returns the selected byte or halfword in the low bits, with the upper bits zero.
- R6: A write to the stream data port with byte enables 4'b1111 stores the word at the stream pointer's word, then adds 4 to the stream pointer.
- R7: A write to the stream data port with any other byte-enable pattern stores nothing and leaves the stream pointer unchanged.
- R8: A read of the stream pointer returns its current value, which is the byte address just past the last streamed word.
- R9: Writes never deassert bus_ready. A stream of 0xC000 zero words completes in exactly 0xC000 cycles.
- R10: After a read is accepted, bus_ready stays low until its single bus_rvalid pulse. At most one read is in flight at any time.
- R11: A write to either pointer register updates only the byte lanes enabled by bus_be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_off | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_wr | input | 1 | Write request, held until accepted |
| bus_rd | input | 1 | Read request, held until accepted |
| bus_ready | output | 1 | Request accepted on this edge when high |
| bus_rvalid | output | 1 | Read data valid, one cycle per read |
| bus_rdata | output | 32 | Read data |

## Verification
The hardest situation to reach is the R9 sustained stream. It needs 0xC000 writes with the bus never stalling, followed by a pointer that has wrapped far past the memory size while the memory itself has wrapped many times. The stimulus drives 0xC000 back-to-back writes to the stream port and counts the clock edges they take. It then reads back the pointer and samples memory words that earlier tests had filled. Lane merging is reached by writing a known word and then overlaying a byte and a halfword through different pointer low bits.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int OFF_W  = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    localparam logic [OFF_W-1:0] OFF_PTR_RND = 8'h10;
    localparam logic [OFF_W-1:0] OFF_DAT_RND = 8'h14;
    localparam logic [OFF_W-1:0] OFF_PTR_STR = 8'h18;
    localparam logic [OFF_W-1:0] OFF_DAT_STR = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PTR_RND,
        SEL_DAT_RND,
        SEL_PTR_STR,
        SEL_DAT_STR
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } xfer_size_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } mem_op_t;

    typedef struct packed {
        xfer_size_e  sz;
        logic [1:0]  lo;
    } rd_fmt_t;

    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
        case (off)
            OFF_PTR_RND: decode_off = SEL_PTR_RND;
            OFF_DAT_RND: decode_off = SEL_DAT_RND;
            OFF_PTR_STR: decode_off = SEL_PTR_STR;
            OFF_DAT_STR: decode_off = SEL_DAT_STR;
            default:     decode_off = SEL_NONE;
        endcase
    endfunction

    function automatic xfer_size_e be_size(input logic [LANES-1:0] be);
        if (be == 4'b1111)  be_size = SZ_WORD;
        else if (be[1])     be_size = SZ_HALF;
        else                be_size = SZ_BYTE;
    endfunction

    function automatic logic [1:0] lane_start(input xfer_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_WORD: lane_start = 2'd0;
            SZ_HALF: lane_start = {lo[1], 1'b0};
            default: lane_start = lo;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input xfer_size_e sz, input logic [1:0] lo);
        logic [LANES-1:0] base;
        case (sz)
            SZ_WORD: base = 4'b1111;
            SZ_HALF: base = 4'b0011;
            default: base = 4'b0001;
        endcase
        lane_mask = base << lane_start(sz, lo);
    endfunction

    function automatic logic [WORD_W-1:0] place_data(input xfer_size_e sz, input logic [1:0] lo,
                                                     input logic [WORD_W-1:0] d);
        place_data = d << {lane_start(sz, lo), 3'b000};
    endfunction

    function automatic logic [WORD_W-1:0] pick_data(input rd_fmt_t f, input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] sh;
        sh = w >> {lane_start(f.sz, f.lo), 3'b000};
        case (f.sz)
            SZ_WORD: pick_data = sh;
            SZ_HALF: pick_data = {16'h0, sh[15:0]};
            default: pick_data = {24'h0, sh[7:0]};
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] old_v,
                                                      input logic [WORD_W-1:0] new_v,
                                                      input logic [LANES-1:0] be);
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int i = 0; i < LANES; i++)
            if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        merge_lanes = r;
    endfunction

endpackage

// File: rtl/mw_mem.sv
module mw_mem
    import mw_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int LAT   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_op_t           op_in,
    input  logic [IDX_W-1:0]  idx_in,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata
);

    mem_op_t          stg_op  [LAT];
    logic [IDX_W-1:0] stg_idx [LAT];
    logic [LAT-1:0]   rd_live;
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg_op[0].valid <= 1'b0;
        else     stg_op[0].valid <= op_in.valid;
        stg_op[0].we    <= op_in.we;
        stg_op[0].be    <= op_in.be;
        stg_op[0].wdata <= op_in.wdata;
        stg_idx[0]      <= idx_in;
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_op[s].valid <= 1'b0;
            else     stg_op[s].valid <= stg_op[s-1].valid;
            stg_op[s].we    <= stg_op[s-1].we;
            stg_op[s].be    <= stg_op[s-1].be;
            stg_op[s].wdata <= stg_op[s-1].wdata;
            stg_idx[s]      <= stg_idx[s-1];
        end
    end

    always_comb begin
        for (int s = 0; s < LAT; s++)
            rd_live[s] = stg_op[s].valid & ~stg_op[s].we;
    end

    always_ff @(posedge clk) begin
        if (stg_op[LAT-1].valid && stg_op[LAT-1].we) begin
            for (int i = 0; i < LANES; i++)
                if (stg_op[LAT-1].be[i])
                    store[stg_idx[LAT-1]][i*8 +: 8] <= stg_op[LAT-1].wdata[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= rd_live[LAT-1];
        rdata <= store[stg_idx[LAT-1]];
    end

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_live, rvalid}) <= 1);

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [WORD_W-1:0] bus_rdata,
    output mem_op_t           mem_op,
    output logic [IDX_W-1:0]  mem_idx,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);

    logic [WORD_W-1:0] ptr_rnd, ptr_str;
    logic              busy;
    logic              acc, acc_wr, acc_rd;
    reg_sel_e          sel;
    xfer_size_e        sz;
    logic              full_be;
    logic              reg_rvalid;
    logic [WORD_W-1:0] reg_rdata;
    rd_fmt_t           fmt;

    assign bus_ready = ~busy;
    assign acc       = (bus_wr | bus_rd) & bus_ready;
    assign acc_wr    = acc & bus_wr;
    assign acc_rd    = acc & bus_rd & ~bus_wr;
    assign sel       = decode_off(bus_off);
    assign sz        = be_size(bus_be);
    assign full_be   = (bus_be == 4'b1111);

    always_comb begin
        mem_op.valid = 1'b0;
        mem_op.we    = bus_wr;
        mem_op.be    = 4'b1111;
        mem_op.wdata = bus_wdata;
        mem_idx      = ptr_rnd[IDX_W+1:2];
        if (sel == SEL_DAT_RND) begin
            mem_op.valid = acc;
            mem_op.be    = lane_mask(sz, ptr_rnd[1:0]);
            mem_op.wdata = place_data(sz, ptr_rnd[1:0], bus_wdata);
        end else if (sel == SEL_DAT_STR) begin
            mem_op.valid = acc_wr & full_be;
            mem_idx      = ptr_str[IDX_W+1:2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_rnd <= '0;
            ptr_str <= '0;
        end else if (acc_wr) begin
            case (sel)
                SEL_PTR_RND: ptr_rnd <= merge_lanes(ptr_rnd, bus_wdata, bus_be);
                SEL_PTR_STR: ptr_str <= merge_lanes(ptr_str, bus_wdata, bus_be);
                SEL_DAT_STR: if (full_be) ptr_str <= ptr_str + 32'd4;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
            fmt        <= '{sz: SZ_WORD, lo: 2'd0};
        end else begin
            reg_rvalid <= acc_rd & (sel != SEL_DAT_RND);
            if (acc_rd) begin
                busy <= 1'b1;
                case (sel)
                    SEL_PTR_RND: reg_rdata <= ptr_rnd;
                    SEL_PTR_STR: reg_rdata <= ptr_str;
                    default:     reg_rdata <= '0;
                endcase
                if (sel == SEL_DAT_RND) fmt <= '{sz: sz, lo: ptr_rnd[1:0]};
                else                    fmt <= '{sz: SZ_WORD, lo: 2'd0};
            end else if (bus_rvalid) begin
                busy <= 1'b0;
            end
        end
    end

    assign bus_rvalid = mem_rvalid | reg_rvalid;
    assign bus_rdata  = mem_rvalid ? pick_data(fmt, mem_rdata) : reg_rdata;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ptr_rnd == '0 && ptr_str == '0));

    // R6
    str_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && sel == SEL_DAT_STR && full_be) |=> ptr_str == $past(ptr_str) + 32'd4);

    // R7
    str_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && sel == SEL_DAT_STR && !full_be) |=> $stable(ptr_str));

    // R9
    wr_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ready) |=> bus_ready);

    // R10
    rd_ready_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> !bus_ready);

endmodule

// File: rtl/mw_window.sv
module mw_window
    import mw_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int MEM_LAT = 2,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_off,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic        bus_ready,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata
);

    mem_op_t           op;
    logic [IDX_W-1:0]  idx;
    logic              m_rvalid;
    logic [WORD_W-1:0] m_rdata;

    mw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_off    (bus_off),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .mem_op     (op),
        .mem_idx    (idx),
        .mem_rvalid (m_rvalid),
        .mem_rdata  (m_rdata)
    );

    mw_mem #(.DEPTH(DEPTH), .LAT(MEM_LAT)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .op_in  (op),
        .idx_in (idx),
        .rvalid (m_rvalid),
        .rdata  (m_rdata)
    );

endmodule

// File: tb/mw_window_test.sv
module mw_window_test;

    localparam int WORDS = 2048;
    localparam logic [7:0] P_RND = 8'h10, D_RND = 8'h14, P_STR = 8'h18, D_STR = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mw_window uut (
        .clk(clk), .rst(rst), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rvalid", bus_rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
        bus_off = off; bus_wdata = d; bus_be = be; bus_wr = 1'b1; bus_rd = 1'b0;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [3:0] be, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_off = off; bus_be = be; bus_rd = 1'b1; bus_wr = 1'b0;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        // R10: stall visible right after the read is taken
        chk(bus_ready == 1'b0, "R10 ready low after read", {31'h0, bus_ready}, 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        chk(bus_ready === 1'b1, "R1 ready after reset", {31'h0, bus_ready}, 32'h1);
        rd(P_RND, 4'hF, 32'h0, "R1 random pointer reset");
        rd(P_STR, 4'hF, 32'h0, "R1 stream pointer reset");

        // R2 unmapped offsets and stream data reads
        wr(8'h08, 32'hDEADBEEF, 4'hF);
        wr(8'h20, 32'h00000040, 4'hF);
        rd(8'h08, 4'hF, 32'h0, "R2 unmapped read");
        rd(P_RND, 4'hF, 32'h0, "R2 random pointer untouched");
        rd(P_STR, 4'hF, 32'h0, "R2 stream pointer untouched");
        rd(D_STR, 4'hF, 32'h0, "R2 stream data read zero");

        // R6 / R8 streaming writes
        wr(P_RND, 32'h10C, 4'hF);
        wr(D_RND, 32'h55AA55AA, 4'hF);
        wr(P_STR, 32'h100, 4'hF);
        wr(D_STR, 32'hA0A0A001, 4'hF);
        wr(D_STR, 32'hA0A0A002, 4'hF);
        wr(D_STR, 32'hA0A0A003, 4'hF);
        rd(P_STR, 4'hF, 32'h10C, "R8 stream pointer fill point");
        wr(P_RND, 32'h104, 4'hF);
        rd(D_RND, 4'hF, 32'hA0A0A002, "R6 second streamed word");
        wr(P_RND, 32'h100, 4'hF);
        rd(D_RND, 4'hF, 32'hA0A0A001, "R3 word at pointer");

        // R7 narrow stream write ignored
        wr(D_STR, 32'h12345678, 4'b0011);
        rd(P_STR, 4'hF, 32'h10C, "R7 pointer unchanged");
        wr(P_RND, 32'h10C, 4'hF);
        rd(D_RND, 4'hF, 32'h55AA55AA, "R7 memory unchanged");

        // R4 lane merging
        wr(P_RND, 32'h200, 4'hF);
        wr(D_RND, 32'h11223344, 4'hF);
        wr(P_RND, 32'h201, 4'hF);
        wr(D_RND, 32'h000000EE, 4'b0001);
        wr(P_RND, 32'h202, 4'hF);
        wr(D_RND, 32'h0000BEEF, 4'b0011);
        wr(P_RND, 32'h200, 4'hF);
        rd(D_RND, 4'hF, 32'hBEEFEE44, "R4 byte and half merge");

        // R5 narrow reads
        wr(P_RND, 32'h203, 4'hF);
        rd(D_RND, 4'b0001, 32'h000000BE, "R5 byte lane 3");
        wr(P_RND, 32'h201, 4'hF);
        rd(D_RND, 4'b0011, 32'h0000EE44, "R5 low half");
        wr(P_RND, 32'h202, 4'hF);
        rd(D_RND, 4'b0001, 32'h000000EF, "R5 byte lane 2");

        // R11 pointer lane writes
        wr(P_RND, 32'h000000FF, 4'b0001);
        rd(P_RND, 4'hF, 32'h000002FF, "R11 low lane only");
        wr(P_RND, 32'hAB000000, 4'b1000);
        rd(P_RND, 4'hF, 32'hAB0002FF, "R11 top lane only");

        // R3 wrap modulo depth
        wr(P_RND, 32'h200 + WORDS * 4, 4'hF);
        rd(D_RND, 4'hF, 32'hBEEFEE44, "R3 wrapped index");

        // R9 sustained zero fill
        begin
            int c0;
            wr(P_STR, 32'h0, 4'hF);
            c0 = cyc;
            for (int i = 0; i < 32'hC000; i++) wr(D_STR, 32'h0, 4'hF);
            chk((cyc - c0) == 32'hC000, "R9 stream cycles", cyc - c0, 32'hC000);
        end
        rd(P_STR, 4'hF, 32'h00030000, "R9 pointer after fill");
        wr(P_RND, 32'h200, 4'hF);
        rd(D_RND, 4'hF, 32'h0, "R9 filled word 0x200");
        wr(P_RND, 32'h10C, 4'hF);
        rd(D_RND, 4'hF, 32'h0, "R9 filled word 0x10C");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule